// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the transmit-side descriptor engine of an Ethernet DMA. Software places 4-word descriptors into a small descriptor store that sits inside the block. The engine follows them one after another. For each descriptor it owns, it issues one buffer request (address, length and the first/last/CRC-suppress markers) to a downstream data mover. It then writes word 0 back with the ownership bit cleared and moves to the next descriptor. The next descriptor is the one named by the descriptor's link word, the list base, or the following slot. When the engine meets a descriptor it does not own, it parks in a suspended state. It leaves that state only when software writes a poll request. It then fetches the same descriptor again.

Software works through two plain ports. The first is a 3-entry register port: a control register whose bit 0 is the start enable, a list-base register, and a poll register. The second is a host port into the descriptor store. On the host port, reads are combinational. A host write to the same word in the same cycle as the engine's write-back takes priority over it.

The buffer request is a valid/ready stream. Once `req_valid` rises, the request fields are frozen until the cycle in which `req_ready` is high. Clearing start never withdraws a request that is pending. The data mover may hold `req_ready` low for as long as it likes.

Descriptor words, in memory order, are: word 0 flags with ownership at bit 31, word 1 control and length, word 2 buffer address, word 3 link. Pointers (list base and link) are word addresses into the store; bits [AW-1:2] select the descriptor slot.

Top module: `tx_desc_fetch`

## Requirements
- R1: After reset there is no request (`req_valid`=0), no interrupt and no suspension, and every word of the descriptor store reads 0.
- R2: An owned descriptor produces exactly one request: `req_addr` is word 2 and `req_len` is word 1 bits [LEN_W-1:0]. While `req_ready` is low, `req_valid` stays high and the address and length stay unchanged.
- R3: After a descriptor is handled, its word 0 reads back with bit 31 cleared and every other bit unchanged.
- R4: Fetching a descriptor whose word 0 bit 31 is 0 suspends the engine (`tx_suspended`=1) with no request issued. Writing register 2 with bit 0 set makes the engine fetch that same descriptor again. A poll write with bit 0 clear has no effect.
- R5: The next descriptor is chosen in this order. If the chained flag is set, the slot named by word 3 is used. Otherwise, if the ring-end flag is set, the list base is used. Otherwise the following slot is used, wrapping from the last slot to slot 0.
- R6: In the default layout (`alt_layout`=0) the flags are taken from word 0: interrupt bit 30, last 29, first 28, CRC-suppress 27, ring-end 21, chained 20. The high bits of word 1 are ignored.
- R7: In the alternate layout the flags are taken from word 1: interrupt bit 31, last 30, first 29, CRC-suppress 26, ring-end 25, chained 24. Word 0 flag bits are ignored. `alt_layout` is sampled only while start is clear and the engine is idle.
- R8: `tx_irq` pulses for one cycle after a write-back, and only when the descriptor's interrupt flag was set.
- R9: A descriptor whose length field is 0 issues no request but is still written back with ownership cleared.
- R10: Nothing is fetched while start (register 0 bit 0) is clear, and clearing start ends suspension. A list-base write (register 1) takes effect and repositions the engine only while start is clear and the engine is idle; otherwise it is ignored.
- R11: A host-port write stores its data, and a host read of that word returns it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 list base, 2 poll |
| reg_wdata | input | 32 | Register write data |
| alt_layout | input | 1 | Descriptor layout select (1 = flags in word 1) |
| host_we | input | 1 | Descriptor store write strobe |
| host_addr | input | AW | Descriptor store word address |
| host_wdata | input | 32 | Descriptor store write data |
| host_rdata | output | 32 | Descriptor store read data (combinational) |
| req_valid | output | 1 | Buffer request valid |
| req_ready | input | 1 | Buffer request accepted |
| req_addr | output | 32 | Buffer address |
| req_len | output | LEN_W | Buffer length |
| req_first | output | 1 | First-segment marker |
| req_last | output | 1 | Last-segment marker |
| req_nocrc | output | 1 | CRC-suppress marker |
| tx_irq | output | 1 | Completion interrupt pulse |
| tx_suspended | output | 1 | Engine parked on a descriptor it does not own |

## Verification
The hardest state to reach from the ports is a suspended engine that has already taken a new list base or a new layout value. Both are meant to be blocked while the engine runs. The bench parks the engine on a non-owned descriptor, changes ownership, base and layout through the host and register ports, and polls. It then shows that the request comes from the parked descriptor and is decoded with the layout sampled earlier. A further sequence drives the ring-end return and the wrap from the last slot to slot 0, using marker buffer addresses that identify which slot was fetched. A sweep over both layouts and all sixteen combinations of the interrupt, first, last and CRC-suppress flags places the opposite pattern in the unused layout's bit positions, so that reading the wrong word shows up.

// File: rtl/tdf_pkg.sv
`timescale 1ns/1ps
package tdf_pkg;
  localparam int OWN_BIT = 31;

  // flag positions, default layout (word 0)
  localparam int DF_IRQ = 30;
  localparam int DF_LST = 29;
  localparam int DF_FST = 28;
  localparam int DF_NCR = 27;
  localparam int DF_END = 21;
  localparam int DF_CHN = 20;

  // flag positions, alternate layout (word 1)
  localparam int AF_IRQ = 31;
  localparam int AF_LST = 30;
  localparam int AF_FST = 29;
  localparam int AF_NCR = 26;
  localparam int AF_END = 25;
  localparam int AF_CHN = 24;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_BASE = 2'd1;
  localparam logic [1:0] RA_POLL = 2'd2;

  typedef enum logic [2:0] {
    WS_IDLE, WS_RD0, WS_RD1, WS_RD2, WS_RD3, WS_REQ, WS_WB, WS_SUSP
  } walk_st_e;

  typedef struct packed {
    logic irq_en;
    logic last;
    logic first;
    logic no_crc;
    logic wrap;
    logic chain;
  } dflags_t;

  function automatic dflags_t decode_flags(input logic [31:0] w0,
                                           input logic [31:0] w1,
                                           input logic alt);
    dflags_t f;
    if (alt) begin
      f.irq_en = w1[AF_IRQ];
      f.last   = w1[AF_LST];
      f.first  = w1[AF_FST];
      f.no_crc = w1[AF_NCR];
      f.wrap   = w1[AF_END];
      f.chain  = w1[AF_CHN];
    end else begin
      f.irq_en = w0[DF_IRQ];
      f.last   = w0[DF_LST];
      f.first  = w0[DF_FST];
      f.no_crc = w0[DF_NCR];
      f.wrap   = w0[DF_END];
      f.chain  = w0[DF_CHN];
    end
    return f;
  endfunction
endpackage

// File: rtl/tdf_desc_mem.sv
`timescale 1ns/1ps
module tdf_desc_mem #(
  parameter int WORDS = 32,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] e_addr,
  output logic [31:0]   e_rdata,
  input  logic          e_we,
  input  logic [31:0]   e_wdata,
  input  logic [AW-1:0] h_addr,
  output logic [31:0]   h_rdata,
  input  logic          h_we,
  input  logic [31:0]   h_wdata
);
  logic [31:0] store [WORDS];

  // host write placed last so it overrides an engine write to the same word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else begin
      if (e_we) store[e_addr] <= e_wdata;
      if (h_we) store[h_addr] <= h_wdata;
    end
  end

  assign e_rdata = store[e_addr];
  assign h_rdata = store[h_addr];

  a_r11_host_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    h_we |=> (h_addr != $past(h_addr)) || (h_rdata == $past(h_wdata)));
endmodule

// File: rtl/tdf_regs.sv
`timescale 1ns/1ps
module tdf_regs
  import tdf_pkg::*;
#(
  parameter int MEM_AW = 5,
  localparam int IDX_W = MEM_AW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             alt_sel,
  input  logic             eng_idle,
  output logic             start_q,
  output logic             alt_q,
  output logic             poll_p,
  output logic             base_ld,
  output logic [IDX_W-1:0] base_new,
  output logic [IDX_W-1:0] base_idx
);
  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:MEM_AW], reg_wdata[1]};

  assign base_ld  = reg_we && (reg_addr == RA_BASE) && !start_q && eng_idle;
  assign base_new = reg_wdata[MEM_AW-1:2];
  assign poll_p   = reg_we && (reg_addr == RA_POLL) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      alt_q    <= 1'b0;
      base_idx <= '0;
    end else begin
      if (reg_we && (reg_addr == RA_CTRL)) start_q <= reg_wdata[0];
      if (!start_q && eng_idle) alt_q <= alt_sel;
      if (base_ld) base_idx <= base_new;
    end
  end

  a_r10_base_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_idx) |-> $past(!start_q && eng_idle));
  a_r7_layout_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alt_q) |-> $past(!start_q && eng_idle));
endmodule

// File: rtl/tdf_walker.sv
`timescale 1ns/1ps
module tdf_walker
  import tdf_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             alt,
  input  logic             poll,
  input  logic             base_ld,
  input  logic [IDX_W-1:0] base_new,
  input  logic [IDX_W-1:0] base_idx,
  output logic [IDX_W+1:0] m_addr,
  input  logic [31:0]      m_rdata,
  output logic             m_we,
  output logic [31:0]      m_wdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic             req_first,
  output logic             req_last,
  output logic             req_nocrc,
  output logic             irq,
  output logic             idle,
  output logic             suspended
);
  walk_st_e         st;
  logic [IDX_W-1:0] cur;
  logic [IDX_W-1:0] link_idx;
  logic [IDX_W-1:0] nxt_idx;
  logic [31:0]      w0, w1, w2;
  dflags_t          flg;
  logic [1:0]       off;
  logic             unused_w1;

  assign unused_w1 = ^w1[23:LEN_W];

  always_comb begin
    unique case (st)
      WS_RD1:  off = 2'd1;
      WS_RD2:  off = 2'd2;
      WS_RD3:  off = 2'd3;
      default: off = 2'd0;
    endcase
  end

  always_comb begin
    if (flg.chain)     nxt_idx = link_idx;
    else if (flg.wrap) nxt_idx = base_idx;
    else               nxt_idx = cur + {{(IDX_W-1){1'b0}}, 1'b1};
  end

  assign m_addr    = {cur, off};
  assign m_we      = (st == WS_WB);
  assign m_wdata   = {1'b0, w0[OWN_BIT-1:0]};
  assign req_valid = (st == WS_REQ);
  assign req_addr  = w2;
  assign req_len   = w1[LEN_W-1:0];
  assign req_first = flg.first;
  assign req_last  = flg.last;
  assign req_nocrc = flg.no_crc;
  assign idle      = (st == WS_IDLE);
  assign suspended = (st == WS_SUSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WS_IDLE;
      cur      <= '0;
      link_idx <= '0;
      w0       <= '0;
      w1       <= '0;
      w2       <= '0;
      flg      <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (st)
        WS_IDLE: begin
          if (base_ld) cur <= base_new;
          if (start) st <= WS_RD0;
        end
        WS_RD0: begin
          if (!start)                 st <= WS_IDLE;
          else if (!m_rdata[OWN_BIT]) st <= WS_SUSP;
          else begin
            w0 <= m_rdata;
            st <= WS_RD1;
          end
        end
        WS_RD1: begin
          w1 <= m_rdata;
          st <= WS_RD2;
        end
        WS_RD2: begin
          w2 <= m_rdata;
          st <= WS_RD3;
        end
        WS_RD3: begin
          link_idx <= m_rdata[IDX_W+1:2];
          flg      <= decode_flags(w0, w1, alt);
          st       <= (w1[LEN_W-1:0] == '0) ? WS_WB : WS_REQ;
        end
        WS_REQ: begin
          if (req_ready) st <= WS_WB;
        end
        WS_WB: begin
          cur <= nxt_idx;
          irq <= flg.irq_en;
          st  <= WS_RD0;
        end
        WS_SUSP: begin
          if (!start)    st <= WS_IDLE;
          else if (poll) st <= WS_RD0;
        end
        default: st <= WS_IDLE;
      endcase
    end
  end

  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));
  a_r9_no_empty_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != '0);
  a_r8_irq_follows_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(m_we));
  a_r4_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && start && !poll |=> suspended);
endmodule

// File: rtl/tx_desc_fetch.sv
`timescale 1ns/1ps
module tx_desc_fetch #(
  parameter int DESC_NUM = 8,
  parameter int LEN_W = 11,
  localparam int WORDS = DESC_NUM * 4,
  localparam int AW = $clog2(WORDS),
  localparam int IDX_W = AW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             alt_layout,
  input  logic             host_we,
  input  logic [AW-1:0]    host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [31:0]      req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic             req_first,
  output logic             req_last,
  output logic             req_nocrc,
  output logic             tx_irq,
  output logic             tx_suspended
);
  logic             start_q, alt_q, poll_p, base_ld, eng_idle;
  logic [IDX_W-1:0] base_new, base_idx;
  logic [AW-1:0]    e_addr;
  logic [31:0]      e_rdata, e_wdata;
  logic             e_we;

  tdf_regs #(.MEM_AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .alt_sel(alt_layout), .eng_idle(eng_idle),
    .start_q(start_q), .alt_q(alt_q), .poll_p(poll_p),
    .base_ld(base_ld), .base_new(base_new), .base_idx(base_idx)
  );

  tdf_desc_mem #(.WORDS(WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .e_addr(e_addr), .e_rdata(e_rdata), .e_we(e_we), .e_wdata(e_wdata),
    .h_addr(host_addr), .h_rdata(host_rdata), .h_we(host_we), .h_wdata(host_wdata)
  );

  tdf_walker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(start_q), .alt(alt_q), .poll(poll_p),
    .base_ld(base_ld), .base_new(base_new), .base_idx(base_idx),
    .m_addr(e_addr), .m_rdata(e_rdata), .m_we(e_we), .m_wdata(e_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_first(req_first), .req_last(req_last),
    .req_nocrc(req_nocrc), .irq(tx_irq), .idle(eng_idle),
    .suspended(tx_suspended)
  );
endmodule

// File: tb/sim_tx_desc_fetch.sv
`timescale 1ns/1ps
module sim_tx_desc_fetch;
  localparam int LEN_W = 11;
  localparam logic [31:0] OWN = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        alt_layout = 1'b0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic        req_first, req_last, req_nocrc, tx_irq, tx_suspended;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_desc_fetch u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .alt_layout(alt_layout), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_first(req_first), .req_last(req_last),
    .req_nocrc(req_nocrc), .tx_irq(tx_irq), .tx_suspended(tx_suspended)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic mem_wr(input int a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic mem_rd(input int a, output logic [31:0] d);
    @(negedge clk); host_addr = 5'(a); #1; d = host_rdata;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] e);
    mem_wr(idx*4, a); mem_wr(idx*4+1, b); mem_wr(idx*4+2, c); mem_wr(idx*4+3, e);
  endtask

  task automatic stop_engine();
    reg_wr(2'd0, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic take_req(input string tag, input logic [31:0] ea, input int el,
                          input logic ef, input logic els, input logic enc);
    int t = 0;
    while (!req_valid && t < 60) begin @(negedge clk); t++; end
    check({tag, " R2 valid"}, 32'(req_valid), 32'd1);
    check({tag, " R2 addr"}, req_addr, ea);
    check({tag, " R2 len"}, 32'(req_len), 32'(el));
    check({tag, " R6/R7 first"}, 32'(req_first), 32'(ef));
    check({tag, " R6/R7 last"}, 32'(req_last), 32'(els));
    check({tag, " R6/R7 nocrc"}, 32'(req_nocrc), 32'(enc));
    repeat (2) begin
      @(negedge clk);
      check({tag, " R2 held under backpressure"},
            32'({req_valid, req_addr == ea, 32'(req_len) == 32'(el)}), 32'd7);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic count_irq(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin @(negedge clk); if (tx_irq) cnt++; end
  endtask

  task automatic wait_susp(input string tag);
    int t = 0;
    while (!tx_suspended && t < 60) begin @(negedge clk); t++; end
    check({tag, " R4 suspended"}, 32'(tx_suspended), 32'd1);
  endtask

  task automatic no_req(input string tag, input int n);
    int seen = 0;
    repeat (n) begin @(negedge clk); if (req_valid) seen++; end
    check({tag, " no request"}, 32'(seen), 32'd0);
  endtask

  function automatic logic [31:0] dbits(input int f);
    return (32'(f & 1) << 30) | (32'((f >> 2) & 1) << 29) |
           (32'((f >> 1) & 1) << 28) | (32'((f >> 3) & 1) << 27);
  endfunction

  function automatic logic [31:0] abits(input int f);
    return (32'(f & 1) << 31) | (32'((f >> 2) & 1) << 30) |
           (32'((f >> 1) & 1) << 29) | (32'((f >> 3) & 1) << 26);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, w0, w1, w2;
    int ic;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 req_valid", 32'(req_valid), 32'd0);
    check("R1 irq", 32'(tx_irq), 32'd0);
    check("R1 suspended", 32'(tx_suspended), 32'd0);
    mem_rd(0, rd);  check("R1 store word 0", rd, 32'd0);
    mem_rd(31, rd); check("R1 store word 31", rd, 32'd0);
    // R11 host port
    mem_wr(9, 32'h1234_5678);
    mem_rd(9, rd); check("R11 host readback", rd, 32'h1234_5678);

    // sweep: both layouts x all irq/first/last/nocrc combinations
    for (int lay = 0; lay < 2; lay++) begin
      for (int f = 0; f < 16; f++) begin
        int len;
        string tag;
        tag = $sformatf("sweep lay=%0d f=%0d", lay, f);
        stop_engine();
        alt_layout = lay[0];
        len = 1 + f * 37 + lay * 500;
        if (lay == 0) begin
          w0 = OWN | dbits(f);
          w1 = 32'(len) | abits(~f & 15);
        end else begin
          w0 = OWN | dbits(~f & 15);
          w1 = 32'(len) | abits(f);
        end
        w2 = 32'hA000_0000 + 32'(f * 16 + lay * 256);
        put_desc(0, w0, w1, w2, 32'd0);
        mem_wr(4, 32'd0);
        reg_wr(2'd1, 32'd0);
        reg_wr(2'd0, 32'd1);
        take_req(tag, w2, len, f[1], f[2], f[3]);
        count_irq(8, ic);
        check({tag, " R8 irq count"}, 32'(ic), 32'(f & 1));
        wait_susp(tag);
        mem_rd(0, rd);
        check({tag, " R3 writeback"}, rd, w0 & ~OWN);
      end
    end

    // R5 chained link and ring-end return to base
    stop_engine();
    alt_layout = 0;
    put_desc(0, OWN | (32'd1 << 20), 32'd100, 32'hB000_0000, 32'd20);
    put_desc(5, OWN | (32'd1 << 21), 32'd200, 32'hB000_0005, 32'd12);
    put_desc(3, OWN, 32'd77, 32'hDEAD_0003, 32'd0);
    reg_wr(2'd1, 32'd0);
    reg_wr(2'd0, 32'd1);
    take_req("R5 chained", 32'hB000_0000, 100, 1'b0, 1'b0, 1'b0);
    take_req("R5 link target", 32'hB000_0005, 200, 1'b0, 1'b0, 1'b0);
    wait_susp("R5 ring-end back to base");
    mem_rd(20, rd); check("R3 chained writeback", rd, 32'h0020_0000);

    // R4: no resume without poll, poll with bit0 clear ignored, poll resumes
    mem_wr(1, 32'd300);
    mem_wr(2, 32'hB100_0000);
    mem_wr(0, OWN | (32'd1 << 20));
    no_req("R4 stays parked", 10);
    reg_wr(2'd2, 32'hFFFF_FFFE);
    no_req("R4 poll bit0 clear ignored", 10);
    check("R4 still suspended", 32'(tx_suspended), 32'd1);
    reg_wr(2'd2, 32'd1);
    take_req("R4 poll refetch", 32'hB100_0000, 300, 1'b0, 1'b0, 1'b0);
    wait_susp("R4 parked on slot 5");

    // R10/R7: base write and layout change while running are ignored
    reg_wr(2'd1, 32'd8);
    put_desc(2, OWN, 32'd55, 32'hDEAD_0002, 32'd0);
    alt_layout = 1;
    put_desc(5, OWN | (32'd1 << 28), 32'd40, 32'hB500_0000, 32'd0);
    mem_wr(24, 32'd0);
    reg_wr(2'd2, 32'd1);
    take_req("R10/R7 run-time writes ignored", 32'hB500_0000, 40, 1'b1, 1'b0, 1'b0);
    wait_susp("R5 next slot");

    // R10: stop ends suspension, nothing fetched while stopped
    reg_wr(2'd0, 32'd0);
    @(negedge clk);
    check("R10 suspension cleared by stop", 32'(tx_suspended), 32'd0);
    put_desc(6, OWN, 32'd66, 32'hDEAD_0006, 32'd0);
    reg_wr(2'd2, 32'd1);
    no_req("R10 stopped", 12);

    // R5 sequential increment and wrap from last slot to slot 0
    alt_layout = 0;
    repeat (2) @(negedge clk);
    reg_wr(2'd1, 32'd24);
    put_desc(6, OWN, 32'd11, 32'hC000_0006, 32'd0);
    put_desc(7, OWN, 32'd12, 32'hC000_0007, 32'd0);
    put_desc(0, OWN, 32'd13, 32'hC000_0000, 32'd0);
    mem_wr(4, 32'd0);
    reg_wr(2'd0, 32'd1);
    take_req("R5 base slot 6", 32'hC000_0006, 11, 1'b0, 1'b0, 1'b0);
    take_req("R5 slot 7", 32'hC000_0007, 12, 1'b0, 1'b0, 1'b0);
    take_req("R5 wrap slot 0", 32'hC000_0000, 13, 1'b0, 1'b0, 1'b0);
    wait_susp("R5 slot 1");

    // R9 zero length: no request, ownership cleared, irq still raised
    stop_engine();
    reg_wr(2'd1, 32'd0);
    put_desc(0, OWN | (32'd1 << 30), 32'h0000_F800, 32'hE000_0000, 32'd0);
    mem_wr(4, 32'd0);
    reg_wr(2'd0, 32'd1);
    begin
      int seen = 0;
      ic = 0;
      repeat (20) begin
        @(negedge clk);
        if (req_valid) seen++;
        if (tx_irq) ic++;
      end
      check("R9 no request for empty", 32'(seen), 32'd0);
      check("R8 irq on empty descriptor", 32'(ic), 32'd1);
    end
    check("R9 parked after empty", 32'(tx_suspended), 32'd1);
    mem_rd(0, rd); check("R9 ownership cleared", rd, 32'h4000_0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule